// File: doc/BRIEF.md
# GPIO Port Interrupt Status Logic

This block detects interrupts on the pins of one general-purpose input port. Each pin passes through a synchronizer, and optionally through a debouncer. Its status is then judged in one of two ways, chosen per pin. In level mode the status follows the pin at the selected polarity. In edge mode the status captures the selected transition and holds it until software acknowledges it.

Software works the block through a simple register bus: a write strobe, an address, write data and combinational read data. Two views of the status are kept. The raw view shows what each pin would signal, whatever its enable bit. The masked view gates the raw view with the per-pin enable. The single interrupt line `irq_o` is the OR of the masked view.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the mode register is 0 (all pins level), the polarity register is all ones, enable and debounce-enable are 0, and raw status, masked status and `irq_o` are all 0.
- R2: A level pin with polarity 1 has a raw status equal to its synchronized pin. This appears two clock edges after the pin changes and clears by itself when the pin drops.
- R3: A level pin with polarity 0 has a raw status equal to its inverted synchronized pin.
- R4: An edge pin (mode bit 1) latches raw status 1 on a rising transition when its polarity bit is 1, and on a falling transition when it is 0. The opposite transition sets nothing.
- R5: A latched edge bit stays 1 after the pin returns. It clears only when 1 is written to that bit at the acknowledge address. Writing 0 there changes nothing.
- R6: When a new edge and an acknowledge of the same bit hit the same clock edge, the bit ends set.
- R7: Raw status does not depend on the enable register. The masked status (address 6) equals raw AND enable.
- R8: `irq_o` is 1 exactly when some masked status bit is 1.
- R9: With the debounce bit set, a pin change reaches the status only after the synchronized pin has differed from the filtered value for 4 consecutive clocks. Shorter pulses are ignored.
- R10: Register map: 0 mode, 1 polarity, 2 enable, 3 debounce-enable, 4 acknowledge, 5 raw status, 6 masked status. Registers 0 to 3 read back as written. Address 4 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr, combinational |
| pins_i | input | NPINS | Asynchronous pin inputs |
| irq_o | output | 1 | Port interrupt, OR of masked status |

## Verification
The bench builds the block with its defaults: eight pins, a two-stage synchronizer and a four-clock debounce window. With those values the exact latencies can be checked cycle by cycle. The level output appears after two edges, an edge latches after three, and a debounced change takes six. A three-clock glitch sits one clock short of the filter window, so both sides of the window's boundary are exercised. The short synchronizer also lets an acknowledge write be placed on the same edge as a fresh latch, which is the set-over-clear case.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   // register offsets on the port bus
   localparam int unsigned OFS_MODE = 0;
   localparam int unsigned OFS_POL  = 1;
   localparam int unsigned OFS_EN   = 2;
   localparam int unsigned OFS_DBEN = 3;
   localparam int unsigned OFS_ACK  = 4;
   localparam int unsigned OFS_RAW  = 5;
   localparam int unsigned OFS_MSK  = 6;
   localparam int unsigned OFS_LAST = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int W     = 8,
   parameter int TICKS = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (TICKS < 1) begin : g_bad_ticks
      $error("gpio_debounce: TICKS must be at least 1");
   end

   if (TICKS == 1) begin : g_direct
      // one-sample filter: plain register
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= '0;
         else        q_o <= d_i;
      end
   end else begin : g_filter
      localparam int CW = $clog2(TICKS);
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

      for (genvar i = 0; i < W; i++) begin : g_pin
         logic [CW-1:0] run_q;
         logic          keep_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               keep_q <= 1'b0;
            end else if (d_i[i] == keep_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               keep_q <= d_i[i];
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign q_o[i] = keep_q;
      end
   end
endmodule

// File: rtl/gpio_pin_status.sv
module gpio_pin_status #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] mode_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] ack_i,
   output logic [W-1:0] set_o,
   output logic [W-1:0] raw_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] latch_q;
   logic [W-1:0] rise;
   logic [W-1:0] fall;

   assign rise  = lvl_i & ~prev_q;
   assign fall  = ~lvl_i & prev_q;
   assign set_o = (pol_i & rise) | (~pol_i & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= lvl_i;
         // a fresh edge overrides an acknowledge in the same cycle
         latch_q <= set_o | (latch_q & ~ack_i);
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_sel
      always_comb begin
         if (mode_i[i]) raw_o[i] = latch_q[i];
         else           raw_o[i] = ~(lvl_i[i] ^ pol_i[i]);
      end
   end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
   parameter int NPINS       = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DB_TICKS    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pins_i,
   output logic              irq_o
);
   import gpio_irq_pkg::*;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_irq_port: NPINS out of range 1..32");
   end
   if ((1 << ADDR_W) <= OFS_LAST) begin : g_bad_addr
      $error("gpio_irq_port: ADDR_W too small for register map");
   end

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_DBEN = ADDR_W'(OFS_DBEN);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);

   logic [NPINS-1:0] type_q, pol_q, en_q, dben_q;
   logic [NPINS-1:0] sync_w, filt_w, lvl_w;
   logic [NPINS-1:0] eoi_clr, edge_set, raw_st, msk_st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         type_q <= '0;
         pol_q  <= '1;
         en_q   <= '0;
         dben_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_MODE:  type_q <= bus_wdata;
            A_POL:   pol_q  <= bus_wdata;
            A_EN:    en_q   <= bus_wdata;
            A_DBEN:  dben_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign eoi_clr = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_w)
   );

   gpio_debounce #(.W(NPINS), .TICKS(DB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .d_i(sync_w), .q_o(filt_w)
   );

   assign lvl_w = (dben_q & filt_w) | (~dben_q & sync_w);

   gpio_pin_status #(.W(NPINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .mode_i(type_q),
      .pol_i(pol_q), .ack_i(eoi_clr), .set_o(edge_set), .raw_o(raw_st)
   );

   assign msk_st = raw_st & en_q;
   assign irq_o  = |msk_st;

   always_comb begin
      case (bus_addr)
         A_MODE:  bus_rdata = type_q;
         A_POL:   bus_rdata = pol_q;
         A_EN:    bus_rdata = en_q;
         A_DBEN:  bus_rdata = dben_q;
         A_RAW:   bus_rdata = raw_st;
         A_MSK:   bus_rdata = msk_st;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NPINS-1:0]  bus_rdata,
   input logic [NPINS-1:0]  type_q,
   input logic [NPINS-1:0]  en_q,
   input logic [NPINS-1:0]  eoi_clr,
   input logic [NPINS-1:0]  edge_set,
   input logic [NPINS-1:0]  raw_st,
   input logic              irq_o
);
   // R10
   ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(gpio_irq_pkg::OFS_ACK)) |-> (bus_rdata == '0));

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_o);

   // R7
   irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (raw_st != '0));

   for (genvar i = 0; i < NPINS; i++) begin : g_bit
      // R5
      edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (type_q[i] && raw_st[i] && !eoi_clr[i]) |=> (!type_q[i] || raw_st[i]));

      // R5
      edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (type_q[i] && eoi_clr[i] && !edge_set[i]) |=> (!type_q[i] || !raw_st[i]));

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (type_q[i] && edge_set[i]) |=> (!type_q[i] || raw_st[i]));
   end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .type_q(type_q), .en_q(en_q), .eoi_clr(eoi_clr), .edge_set(edge_set),
   .raw_st(raw_st), .irq_o(irq_o)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
   localparam int N = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [N-1:0]  bus_wdata = '0;
   logic [N-1:0]  bus_rdata;
   logic [N-1:0]  pins = '0;
   logic          irq_o;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   gpio_irq_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_i(pins), .irq_o(irq_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [N-1:0] d);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [N-1:0] d);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [N-1:0] v;
      rd(0, v); check("R1 mode", v, 8'h00);
      rd(1, v); check("R1 pol", v, 8'hFF);
      rd(2, v); check("R1 en", v, 8'h00);
      rd(3, v); check("R1 dben", v, 8'h00);
      rd(5, v); check("R1 raw", v, 8'h00);
      rd(6, v); check("R1 masked", v, 8'h00);
      check("R1 irq", {7'b0, irq_o}, 8'h00);
   endtask

   task automatic t_level_high;
      logic [N-1:0] v;
      pins[0] = 1'b1;
      tick(1); rd(5, v); check("R2 one edge", v, 8'h00);
      tick(1); rd(5, v); check("R2 follows", v, 8'h01);
      pins[0] = 1'b0;
      tick(2); rd(5, v); check("R2 self clear", v, 8'h00);
   endtask

   task automatic t_level_low;
      logic [N-1:0] v;
      wr(1, 8'hF7);
      rd(5, v); check("R3 low pin", v, 8'h08);
      pins[3] = 1'b1;
      tick(2); rd(5, v); check("R3 high pin", v, 8'h00);
      pins[3] = 1'b0;
      wr(1, 8'hFF);
      tick(2);
   endtask

   task automatic t_edge_rise;
      logic [N-1:0] v;
      wr(0, 8'h01);
      pins[0] = 1'b1;
      tick(3); rd(5, v); check("R4 rise latch", v, 8'h01);
      pins[0] = 1'b0;
      tick(3); rd(5, v); check("R5 hold", v, 8'h01);
      wr(4, 8'h00);
      rd(5, v); check("R5 ack zero ignored", v, 8'h01);
      wr(4, 8'h01);
      rd(5, v); check("R5 ack clears", v, 8'h00);
   endtask

   task automatic t_edge_fall;
      logic [N-1:0] v;
      wr(0, 8'h05);
      wr(1, 8'hFB);
      pins[2] = 1'b1;
      tick(3); rd(5, v); check("R4 rise ignored on fall pin", v, 8'h00);
      pins[2] = 1'b0;
      tick(3); rd(5, v); check("R4 fall latch", v, 8'h04);
      wr(4, 8'h04);
      rd(5, v); check("R5 ack fall bit", v, 8'h00);
      wr(1, 8'hFF);
   endtask

   task automatic t_set_wins;
      logic [N-1:0] v;
      pins[0] = 1'b1;
      tick(2);
      wr(4, 8'h01);   // lands on the same edge as the latch
      rd(5, v); check("R6 set over clear", v, 8'h01);
      wr(4, 8'h01);
      rd(5, v); check("R6 later ack", v, 8'h00);
      pins[0] = 1'b0;
      tick(3);
   endtask

   task automatic t_mask;
      logic [N-1:0] v;
      pins[0] = 1'b1;
      tick(3);
      rd(5, v); check("R7 raw without enable", v, 8'h01);
      rd(6, v); check("R7 masked off", v, 8'h00);
      check("R8 irq off", {7'b0, irq_o}, 8'h00);
      wr(2, 8'h01);
      rd(6, v); check("R7 masked on", v, 8'h01);
      check("R8 irq on", {7'b0, irq_o}, 8'h01);
      wr(2, 8'hFE);
      rd(5, v); check("R7 raw other enables", v, 8'h01);
      check("R8 irq other enables", {7'b0, irq_o}, 8'h00);
      pins[0] = 1'b0;
      wr(4, 8'h01);
      wr(2, 8'h00);
      wr(0, 8'h00);
   endtask

   task automatic t_debounce;
      logic [N-1:0] v;
      wr(3, 8'h02);
      pins[1] = 1'b1;
      tick(3);
      pins[1] = 1'b0;
      tick(8); rd(5, v); check("R9 glitch filtered", v, 8'h00);
      pins[1] = 1'b1;
      tick(5); rd(5, v); check("R9 before window", v, 8'h00);
      tick(1); rd(5, v); check("R9 after window", v, 8'h02);
      pins[1] = 1'b0;
      tick(6); rd(5, v); check("R9 release", v, 8'h00);
   endtask

   task automatic t_regmap;
      logic [N-1:0] v;
      wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h00); wr(3, 8'h81);
      rd(0, v); check("R10 mode", v, 8'hA5);
      rd(1, v); check("R10 pol", v, 8'h3C);
      rd(3, v); check("R10 dben", v, 8'h81);
      rd(4, v); check("R10 ack reads 0", v, 8'h00);
      rd(7, v); check("R10 unused", v, 8'h00);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_level_high();
      t_level_low();
      t_edge_rise();
      t_edge_fall();
      t_set_wins();
      t_mask();
      t_debounce();
      t_regmap();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule